// File: doc/BRIEF.md
# Six-Channel DMA Bus Arbiter

This block decides which of six DMA channels owns the shared system bus. Each channel raises a request line while it has work pending. The arbiter grants the bus to exactly one channel. It keeps that grant until the channel signals the end of a transfer unit with a done pulse. It then either releases the bus or keeps it, according to the bus-holding mode configured for that channel.

Two priority schemes are available, chosen by one global select:
- **Fixed priority:** the lowest-numbered requesting channel wins.
- **Rotating priority:** the channel that has just been served drops to the bottom, and the channel after it moves to the top.

Each channel independently chooses one of three holding modes:
- **Burst:** keeps the bus until the final transfer.
- **Normal cycle-steal:** hands the bus back after every unit.
- **Intermittent cycle-steal:** hands the bus back and then holds off every DMA grant for a programmable gap of 16 or 64 clocks.

The grant and the bus-busy flag are registered outputs. Arbitration happens only while no channel holds the bus, so a grant never changes in the middle of a transfer unit.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, and at all times, `gnt_o` has at most one bit set. Bit n means channel n owns the bus. Reset clears `gnt_o` and `busy_o`.
- R2: With `rr_mode_i`=0 (fixed), a free bus is granted to the requesting channel with the lowest index, one clock after the request is seen.
- R3: With `rr_mode_i`=1 (rotating), after channel c releases the bus, the search for the next grant starts at channel c+1 and wraps from 5 to 0. After reset the search starts at channel 0.
- R4: While a grant is held and `done_i` is low, the grant does not change, whatever happens on `req_i`.
- R5: A channel in normal cycle-steal mode (`burst_i`[n]=0, `intermit_i`[n]=0) releases the bus at `done_i`. The grant stays all-zero for exactly one clock before the next grant.
- R6: A channel in intermittent mode (`burst_i`[n]=0, `intermit_i`[n]=1) releases the bus at `done_i`. No channel is granted for exactly 16 clocks (`gap_long_i`=0) or 64 clocks (`gap_long_i`=1). `gap_long_i` is sampled at the release.
- R7: A channel in burst mode (`burst_i`[n]=1) keeps the grant across a `done_i` pulse with `last_i`=0. It releases the bus, as in normal mode, on a `done_i` pulse with `last_i`=1.
- R8: `busy_o` is high exactly when some bit of `gnt_o` is set.
- R9: A `done_i` pulse while no channel is granted has no effect: no grant appears from it, and the rotating search start is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Pending-request line of each channel |
| burst_i | input | 6 | Per-channel burst-hold enable |
| intermit_i | input | 6 | Per-channel intermittent cycle-steal enable (used when burst is off) |
| rr_mode_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| gap_long_i | input | 1 | Intermittent gap length: 0 = 16 clocks, 1 = 64 clocks |
| done_i | input | 1 | One-clock pulse: granted channel finished a transfer unit |
| last_i | input | 1 | Qualifies `done_i`: this was the final unit of the channel's run |
| gnt_o | output | 6 | One-hot bus grant |
| busy_o | output | 1 | Bus held by a DMA channel |

## Verification
The priority logic is tested with a sparse request pattern under fixed priority, which must pick the lowest index every time. All six channels are then requested under rotating priority, which must walk 0 through 5 and wrap; this separates a correct pointer update from one that is stuck or off by one. The holding modes are tested one at a time with a single requester:
- The count of zero-grant clocks after each done pulse tells normal mode (1) apart from the short intermittent gap (16) and the long one (64).
- A burst channel is driven with done pulses both without and with the last flag, which shows hold versus release.
- Request changes during a held grant, and a done pulse on an idle bus, check that neither disturbs the grant or the rotation.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OWNED = 2'd1,
    ARB_GAP   = 2'd2
  } arb_state_e;

endpackage

// File: rtl/dma_arb_picker.sv
// Rotating-start priority picker: first requester at or after base_i.
module dma_arb_picker #(
  parameter int NUM_CH = 6,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [IDX_W-1:0]  base_i,
  output logic              vld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_CH-1:0] onehot_o
);

  int c;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    c     = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      c = int'(base_i) + i;
      if (c >= NUM_CH) c = c - NUM_CH;
      if (!vld_o && req_i[c]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(c);
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_oh
      assign onehot_o[g] = vld_o && (idx_o == IDX_W'(g));
    end
  endgenerate

endmodule

// File: rtl/dma_arb_gap_timer.sv
// Down-counter for the enforced idle gap after an intermittent release.
module dma_arb_gap_timer #(
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  localparam int CNT_W = $clog2(GAP_LONG + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic long_i,
  output logic zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? CNT_W'(GAP_LONG - 1) : CNT_W'(GAP_SHORT - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(GAP_LONG - 1)) else $error("gap counter out of range"); // R6

  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("gap counter skipped"); // R6

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_CH    = 6,
  parameter int GAP_SHORT = 16,
  parameter int GAP_LONG  = 64,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] burst_i,
  input  logic [NUM_CH-1:0] intermit_i,
  input  logic              rr_mode_i,
  input  logic              gap_long_i,
  input  logic              done_i,
  input  logic              last_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              busy_o
);
  import dma_arb_pkg::*;

  arb_state_e        state_q;
  logic [NUM_CH-1:0] gnt_q;
  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [IDX_W-1:0]  ptr_q;

  logic [IDX_W-1:0]  base;
  logic              pick_vld;
  logic [IDX_W-1:0]  pick_idx;
  logic [NUM_CH-1:0] pick_oh;
  logic              gap_zero;
  logic              cur_burst;
  logic              cur_int;
  logic              release_now;
  logic              can_arb;
  logic [IDX_W-1:0]  next_ptr;

  assign base = rr_mode_i ? ptr_q : '0;

  dma_arb_picker #(.NUM_CH(NUM_CH)) u_pick (
    .req_i    (req_i),
    .base_i   (base),
    .vld_o    (pick_vld),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  assign cur_burst   = burst_i[cur_q];
  assign cur_int     = intermit_i[cur_q];
  assign release_now = (state_q == ARB_OWNED) && done_i && !(cur_burst && !last_i);
  assign can_arb     = (state_q == ARB_IDLE) || ((state_q == ARB_GAP) && gap_zero);
  assign next_ptr    = (cur_q == IDX_W'(NUM_CH - 1)) ? '0 : cur_q + 1'b1;

  dma_arb_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .load_i (release_now && !cur_burst && cur_int),
    .long_i (gap_long_i),
    .zero_o (gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ARB_OWNED: begin
          if (release_now) begin
            gnt_q   <= '0;
            busy_q  <= 1'b0;
            ptr_q   <= next_ptr;
            state_q <= (!cur_burst && cur_int) ? ARB_GAP : ARB_IDLE;
          end
        end
        default: begin
          if (can_arb && pick_vld) begin
            gnt_q   <= pick_oh;
            busy_q  <= 1'b1;
            cur_q   <= pick_idx;
            state_q <= ARB_OWNED;
          end else if (can_arb) begin
            state_q <= ARB_IDLE;
          end
        end
      endcase
    end
  end

  assign gnt_o  = gnt_q;
  assign busy_o = busy_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)) else $error("grant not one-hot"); // R1

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0 && !done_i) |=> $stable(gnt_o)) else $error("grant moved mid-unit"); // R4

  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (done_i && !last_i && |(gnt_o & burst_i)) |=> $stable(gnt_o)) else $error("burst lost bus"); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done_i && gnt_o != '0 && !(|(gnt_o & burst_i) && !last_i)) |=> (gnt_o == '0))
    else $error("bus not released"); // R5

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    busy_o == (gnt_o != '0)) else $error("busy mismatch"); // R8

  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
    (gnt_o == '0 && done_i && req_i == '0) |=> (gnt_o == '0)) else $error("idle done granted"); // R9

endmodule

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0, burst_i = '0, intermit_i = '0;
  logic         rr_mode_i = 1'b0, gap_long_i = 1'b0, done_i = 1'b0, last_i = 1'b0;
  logic [N-1:0] gnt_o;
  logic         busy_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arbiter u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .burst_i(burst_i), .intermit_i(intermit_i),
    .rr_mode_i(rr_mode_i), .gap_long_i(gap_long_i), .done_i(done_i), .last_i(last_i),
    .gnt_o(gnt_o), .busy_o(busy_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_gnt(input string tag, input logic [N-1:0] exp);
    check(gnt_o == exp, tag, int'(gnt_o), int'(exp));
    check(busy_o == (exp != '0), {tag, " busy R8"}, int'(busy_o), int'(exp != '0));
  endtask

  task automatic do_reset();
    req_i = '0; burst_i = '0; intermit_i = '0; done_i = 0; last_i = 0;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic pulse_done(input logic lst);
    done_i = 1'b1; last_i = lst;
    step();
    done_i = 1'b0; last_i = 1'b0;
  endtask

  function automatic int zero_run_to_int(input int n);
    return n;
  endfunction

  task automatic t_reset();
    do_reset();
    check_gnt("R1 reset state", '0);
  endtask

  task automatic t_fixed();
    do_reset();
    rr_mode_i = 0;
    req_i = 6'b101100;
    step();
    check_gnt("R2 lowest index wins", 6'b000100);
    pulse_done(0);
    check_gnt("R5 normal release", '0);
    step();
    check_gnt("R2 fixed re-pick", 6'b000100);
    req_i = 6'b110000;
    pulse_done(0);
    step();
    check_gnt("R2 new pattern", 6'b010000);
  endtask

  task automatic t_rr();
    do_reset();
    rr_mode_i = 1;
    req_i = '1;
    step();
    check_gnt("R3 first grant ch0", 6'b000001);
    for (int k = 1; k <= 7; k++) begin
      pulse_done(0);
      check_gnt("R5 gap one clock", '0);
      step();
      check_gnt("R3 rotation", 6'(1 << (k % N)));
    end
    req_i = 6'b100001;
    pulse_done(0);
    step();
    check_gnt("R3 skip to ch5", 6'b100000);
    pulse_done(0);
    step();
    check_gnt("R3 wrap to ch0", 6'b000001);
  endtask

  task automatic t_hold();
    do_reset();
    rr_mode_i = 0;
    req_i = 6'b010000;
    step();
    check_gnt("R4 initial grant", 6'b010000);
    for (int k = 0; k < 5; k++) begin
      req_i = 6'(k + 1);
      step();
      check_gnt("R4 grant held", 6'b010000);
    end
  endtask

  task automatic t_burst();
    do_reset();
    burst_i = 6'b001000;
    req_i = 6'b001001;
    rr_mode_i = 1;
    step();
    check_gnt("R3 ch0 first", 6'b000001);
    req_i = 6'b001000;
    pulse_done(0);
    step();
    check_gnt("R7 burst ch3 granted", 6'b001000);
    pulse_done(0);
    check_gnt("R7 burst kept on non-last", 6'b001000);
    pulse_done(0);
    check_gnt("R7 burst kept again", 6'b001000);
    pulse_done(1);
    check_gnt("R7 burst released on last", '0);
    step();
    check_gnt("R7 regrant after burst", 6'b001000);
  endtask

  task automatic measure_gap(input logic longsel, input int exp, input string tag);
    int n;
    gap_long_i = longsel;
    pulse_done(0);
    n = 0;
    while (gnt_o == '0 && n < 200) begin
      n++;
      step();
    end
    check(n == exp, tag, n, exp);
    check(gnt_o == 6'b000010, {tag, " regrant"}, int'(gnt_o), 2);
  endtask

  task automatic t_gap();
    do_reset();
    intermit_i = 6'b000010;
    req_i = 6'b000010;
    step();
    check_gnt("R6 granted ch1", 6'b000010);
    measure_gap(0, 16, "R6 short gap");
    measure_gap(1, 64, "R6 long gap");
    intermit_i = '0;
    measure_gap(1, 1, "R5 normal gap");
  endtask

  task automatic t_idle_done();
    do_reset();
    rr_mode_i = 1;
    pulse_done(0);
    check_gnt("R9 idle done no grant", '0);
    pulse_done(1);
    check_gnt("R9 idle done last", '0);
    req_i = '1;
    step();
    check_gnt("R9 rotation start unchanged", 6'b000001);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fixed();
    t_rr();
    t_hold();
    t_burst();
    t_gap();
    t_idle_done();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule